// File: doc/BRIEF.md
# Filtered receive frame queue

This block sits behind the bit-level receive logic of a CAN-style controller. Each completed frame arrives in one cycle with its identifier, a format flag (standard or extended), a length code and up to eight data bytes. The frame is checked against an eight-entry acceptance table under one global mask. A frame that matches is written into a six-deep queue, together with the index of the table entry that accepted it.

Software always sees the oldest queued frame on one fixed read window. It takes that frame off by writing 1 to the frames-available flag. Three sticky status bits describe the queue: frames available, an almost-full warning at five frames, and overflow. Each bit reaches the interrupt line only when its mask bit is set.

While the queue is full, a matching frame is refused. If that frame also matches an ordinary mailbox, a one-cycle hand-off pulse tells the mailbox path to take it.

Top module: `rxq_filter_fifo`

## Requirements
- R1: After reset, `flags`, `irq` and `frm_to_mbx` are all 0. The mask register resets to all ones and the table entries reset to zero.
- R2: A table entry word holds the format bit at bit 31 and the identifier at bits 29:1. An extended identifier uses bits 29:1, and a standard identifier sits shifted left by one, at bits 11:1. A frame matches an entry only if the format bits are equal and the masked identifier bits are equal.
- R3: A mask word bit at 0, in bits 29:1, makes that identifier bit a don't-care for every entry. A 1 means the bit must compare equal.
- R4: When several entries match, the lowest index wins, and that index is shown on `rd_hit` when the frame is read.
- R5: A frame that matches no entry is not queued.
- R6: Frames leave in arrival order. The head frame is on `rd_*`, and writing 1 to clear bit 0 pops it.
- R7: Flag bit 0 (frames available) is 1 whenever the queue holds a frame. It shows 1 again after a clear if frames remain.
- R8: Flag bit 1 (warning) sets when a push brings the fill level to five. It stays set until a 1 is written to clear bit 1.
- R9: With six frames queued and no pop in the same cycle, a matching frame is refused and flag bit 2 (overflow) sets. A frame is accepted again after a pop.
- R10: A refused frame with `frm_mbx_hit` high gives a one-cycle `frm_to_mbx` pulse in the next cycle.
- R11: A push and a pop in the same cycle while the queue is full are both done, and overflow does not set.
- R12: `irq` is high exactly when some flag bit is 1 and its `imask` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| frm_valid | input | 1 | completed frame present this cycle |
| frm_id | input | 29 | frame identifier (standard id in bits 10:0) |
| frm_ext | input | 1 | 1 = extended format |
| frm_len | input | 4 | length code |
| frm_data | input | 64 | data bytes |
| frm_mbx_hit | input | 1 | frame also matches an ordinary mailbox |
| flt_we | input | 1 | write a table entry |
| flt_idx | input | 3 | table entry index |
| flt_wdata | input | 32 | table entry word |
| msk_we | input | 1 | write global mask |
| msk_wdata | input | 32 | global mask word |
| imask_we | input | 1 | write interrupt mask |
| imask_wdata | input | 3 | interrupt mask (bit0 avail, bit1 warn, bit2 ovf) |
| flag_clr_we | input | 1 | write-1-to-clear strobe |
| flag_clr | input | 3 | flag bits to clear; bit 0 pops |
| rd_id | output | 29 | head frame identifier |
| rd_ext | output | 1 | head frame format |
| rd_len | output | 4 | head frame length code |
| rd_data | output | 64 | head frame data |
| rd_hit | output | 3 | accepting table entry of the head frame |
| flags | output | 3 | {overflow, warning, available} |
| irq | output | 1 | masked interrupt |
| frm_to_mbx | output | 1 | refused frame handed to mailbox path |

## Verification
The case where two functions meet in one cycle is a frame arriving while software pops a full queue. The bench fills the queue to six frames. In a single cycle it then presents a matching frame and writes the pop strobe. It judges the result by the overflow bit staying 0, the head advancing by one, and a drain returning exactly six frames with the new frame last. The opposite case, a frame arriving at full without a pop, must set overflow, pulse the hand-off and leave the head unchanged.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int ID_W   = 29;
    localparam int LEN_W  = 4;
    localparam int DATA_W = 64;
    localparam int NFLT   = 8;
    localparam int HIT_W  = $clog2(NFLT);

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic              ext;
        logic [LEN_W-1:0]  len;
        logic [DATA_W-1:0] data;
        logic [HIT_W-1:0]  hit;
    } rxq_frame_t;
endpackage

// File: rtl/rxq_filter.sv
module rxq_filter
    import rxq_pkg::*;
(
    input  logic [NFLT-1:0][31:0] tbl,
    input  logic [31:0]           mask,
    input  logic [ID_W-1:0]       id,
    input  logic                  ext,
    output logic                  hit,
    output logic [HIT_W-1:0]      hit_idx
);
    logic [ID_W-1:0] key;
    logic [NFLT-1:0] match;

    assign key = ext ? id : {{(ID_W-11){1'b0}}, id[10:0]};

    for (genvar i = 0; i < NFLT; i++) begin : g_ent
        assign match[i] = (tbl[i][31] == ext) &&
                          (((key ^ tbl[i][ID_W:1]) & mask[ID_W:1]) == '0);
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        for (int i = NFLT-1; i >= 0; i--) begin
            if (match[i]) hit_idx = HIT_W'(i);
        end
    end
endmodule

// File: rtl/rxq_queue.sv
module rxq_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  rxq_frame_t       wdata,
    output rxq_frame_t       head,
    output logic [CNT_W-1:0] cnt,
    output logic             full
);
    typedef struct packed {
        rxq_frame_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       wp;
        logic [PTR_W-1:0]       rp;
        logic [CNT_W-1:0]       cnt;
    } q_t;

    q_t q_d, q_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.mem[q_q.wp] = wdata;
            q_d.wp          = nxt(q_q.wp);
        end
        if (pop) q_d.rp = nxt(q_q.rp);
        if (push && !pop)      q_d.cnt = q_q.cnt + 1'b1;
        else if (pop && !push) q_d.cnt = q_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head = q_q.mem[q_q.rp];
    assign cnt  = q_q.cnt;
    assign full = (q_q.cnt == CNT_W'(DEPTH));

    a_r9_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |-> !push);
    a_r6_pop_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt != '0));
    a_r6_fill_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));
    a_r11_fill_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop) |=> (cnt == $past(cnt)));
endmodule

// File: rtl/rxq_filter_fifo.sv
module rxq_filter_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 6,
    parameter int WARN_LVL = 5,
    localparam int CNT_W   = $clog2(DEPTH+1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic [ID_W-1:0]   frm_id,
    input  logic              frm_ext,
    input  logic [LEN_W-1:0]  frm_len,
    input  logic [DATA_W-1:0] frm_data,
    input  logic              frm_mbx_hit,
    input  logic              flt_we,
    input  logic [HIT_W-1:0]  flt_idx,
    input  logic [31:0]       flt_wdata,
    input  logic              msk_we,
    input  logic [31:0]       msk_wdata,
    input  logic              imask_we,
    input  logic [2:0]        imask_wdata,
    input  logic              flag_clr_we,
    input  logic [2:0]        flag_clr,
    output logic [ID_W-1:0]   rd_id,
    output logic              rd_ext,
    output logic [LEN_W-1:0]  rd_len,
    output logic [DATA_W-1:0] rd_data,
    output logic [HIT_W-1:0]  rd_hit,
    output logic [2:0]        flags,
    output logic              irq,
    output logic              frm_to_mbx
);
    typedef struct packed {
        logic [NFLT-1:0][31:0] tbl;
        logic [31:0]           mask;
        logic [2:0]            imask;
        logic                  warn;
        logic                  ovf;
        logic                  to_mbx;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             hit, full, push, pop, reject;
    logic [HIT_W-1:0] hit_idx;
    logic [CNT_W-1:0] cnt;
    rxq_frame_t       wfrm, head;

    rxq_filter i_filter (
        .tbl(ctl_q.tbl), .mask(ctl_q.mask), .id(frm_id), .ext(frm_ext),
        .hit(hit), .hit_idx(hit_idx)
    );

    assign pop    = flag_clr_we && flag_clr[0] && (cnt != '0);
    assign push   = frm_valid && hit && (!full || pop);
    assign reject = frm_valid && hit && full && !pop;
    assign wfrm   = '{id: frm_id, ext: frm_ext, len: frm_len, data: frm_data, hit: hit_idx};

    rxq_queue #(.DEPTH(DEPTH)) i_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .wdata(wfrm),
        .head(head), .cnt(cnt), .full(full)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (flt_we)   ctl_d.tbl[flt_idx] = flt_wdata;
        if (msk_we)   ctl_d.mask = msk_wdata;
        if (imask_we) ctl_d.imask = imask_wdata;
        if (flag_clr_we && flag_clr[1]) ctl_d.warn = 1'b0;
        if (flag_clr_we && flag_clr[2]) ctl_d.ovf  = 1'b0;
        if (push && !pop && cnt == CNT_W'(WARN_LVL-1)) ctl_d.warn = 1'b1;
        if (reject) ctl_d.ovf = 1'b1;
        ctl_d.to_mbx = reject && frm_mbx_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.mask <= '1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_id      = head.id;
    assign rd_ext     = head.ext;
    assign rd_len     = head.len;
    assign rd_data    = head.data;
    assign rd_hit     = head.hit;
    assign flags      = {ctl_q.ovf, ctl_q.warn, cnt != '0};
    assign irq        = |(flags & ctl_q.imask);
    assign frm_to_mbx = ctl_q.to_mbx;

    a_r9_overflow_sets: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> flags[2]);
    a_r10_handoff_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (reject && frm_mbx_hit) |=> frm_to_mbx);
    a_r10_no_stray_handoff: assert property (@(posedge clk) disable iff (!rst_n)
        !reject |=> !frm_to_mbx);
    a_r8_warn_at_level: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> (cnt == CNT_W'(WARN_LVL)));
    a_r11_no_ovf_on_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flags[2] && !reject) |=> !flags[2]);
endmodule

// File: tb/test_rxq_filter_fifo.sv
module test_rxq_filter_fifo;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 0, rst_n = 0;
    logic        frm_valid = 0, frm_ext = 0, frm_mbx_hit = 0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_len = '0;
    logic [63:0] frm_data = '0;
    logic        flt_we = 0, msk_we = 0, imask_we = 0, flag_clr_we = 0;
    logic [2:0]  flt_idx = '0, imask_wdata = '0, flag_clr = '0;
    logic [31:0] flt_wdata = '0, msk_wdata = '0;
    logic [28:0] rd_id;
    logic        rd_ext, irq, frm_to_mbx;
    logic [3:0]  rd_len;
    logic [63:0] rd_data;
    logic [2:0]  rd_hit, flags;

    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_filter_fifo i_rxq_filter_fifo (
        .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_id(frm_id),
        .frm_ext(frm_ext), .frm_len(frm_len), .frm_data(frm_data),
        .frm_mbx_hit(frm_mbx_hit), .flt_we(flt_we), .flt_idx(flt_idx),
        .flt_wdata(flt_wdata), .msk_we(msk_we), .msk_wdata(msk_wdata),
        .imask_we(imask_we), .imask_wdata(imask_wdata),
        .flag_clr_we(flag_clr_we), .flag_clr(flag_clr), .rd_id(rd_id),
        .rd_ext(rd_ext), .rd_len(rd_len), .rd_data(rd_data), .rd_hit(rd_hit),
        .flags(flags), .irq(irq), .frm_to_mbx(frm_to_mbx)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_flt(input int idx, input logic [31:0] w);
        @(negedge clk); flt_we = 1; flt_idx = 3'(idx); flt_wdata = w;
        @(negedge clk); flt_we = 0;
    endtask

    task automatic wr_msk(input logic [31:0] w);
        @(negedge clk); msk_we = 1; msk_wdata = w;
        @(negedge clk); msk_we = 0;
    endtask

    task automatic send(input logic [28:0] id, input logic ext, input logic [63:0] d,
                        input logic mbx, input logic with_pop);
        @(negedge clk);
        frm_valid = 1; frm_id = id; frm_ext = ext; frm_len = 4'd8;
        frm_data = d; frm_mbx_hit = mbx;
        flag_clr_we = with_pop; flag_clr = with_pop ? 3'b001 : 3'b000;
        @(negedge clk);
        frm_valid = 0; frm_mbx_hit = 0; flag_clr_we = 0; flag_clr = '0;
    endtask

    task automatic clr(input logic [2:0] b);
        @(negedge clk); flag_clr_we = 1; flag_clr = b;
        @(negedge clk); flag_clr_we = 0; flag_clr = '0;
    endtask

    task automatic drain(output int n, output logic [63:0] last);
        n = 0; last = '0;
        for (int k = 0; k < 10; k++) begin
            if (flags[0]) begin
                last = rd_data; n++;
                clr(3'b001);
            end
        end
    endtask

    task automatic t_reset;
        chk("R1 flags", 64'(flags), 0);
        chk("R1 irq", 64'(irq), 0);
        chk("R1 handoff", 64'(frm_to_mbx), 0);
    endtask

    task automatic t_std_match;
        int n; logic [63:0] l;
        send(29'h123, 0, 64'hA1, 0, 0);
        chk("R2 std queued", 64'(flags[0]), 1);
        chk("R2 std id", 64'(rd_id), 64'h123);
        chk("R2 len", 64'(rd_len), 8);
        chk("R4 hit idx0", 64'(rd_hit), 0);
        drain(n, l);
        send(29'h124, 0, 64'hA2, 0, 0);
        chk("R5 no match dropped", 64'(flags[0]), 0);
        send(29'h123, 1, 64'hA3, 0, 0);
        chk("R2 format must equal", 64'(flags[0]), 0);
    endtask

    task automatic t_mask_priority;
        int n; logic [63:0] l;
        wr_msk(~(32'h7 << 1));
        send(29'h125, 0, 64'hB1, 0, 0);
        chk("R3 masked bits ignored", 64'(flags[0]), 1);
        chk("R4 lowest entry wins", 64'(rd_hit), 0);
        drain(n, l);
        wr_msk(32'hFFFF_FFFF);
        send(29'h1ABCDE5, 1, 64'hB2, 0, 0);
        chk("R2 ext match", 64'(flags[0]), 1);
        chk("R4 ext hit idx2", 64'(rd_hit), 2);
        chk("R2 ext flag", 64'(rd_ext), 1);
        drain(n, l);
    endtask

    task automatic t_order;
        int n; logic [63:0] l;
        for (int i = 0; i < 3; i++) send(29'h123, 0, 64'(16 + i), 0, 0);
        chk("R6 head first", rd_data, 16);
        clr(3'b001);
        chk("R7 avail reasserts", 64'(flags[0]), 1);
        chk("R6 head second", rd_data, 17);
        drain(n, l);
        chk("R6 last out", l, 18);
        chk("R7 avail clear when empty", 64'(flags[0]), 0);
    endtask

    task automatic t_warn;
        int n; logic [63:0] l;
        for (int i = 0; i < 4; i++) send(29'h123, 0, 64'(i), 0, 0);
        chk("R8 no warn at four", 64'(flags[1]), 0);
        send(29'h123, 0, 64'h4, 0, 0);
        chk("R8 warn at five", 64'(flags[1]), 1);
        clr(3'b001);
        chk("R8 warn sticky", 64'(flags[1]), 1);
        clr(3'b010);
        chk("R8 warn cleared", 64'(flags[1]), 0);
        drain(n, l);
    endtask

    task automatic t_overflow;
        int n; logic [63:0] l;
        for (int i = 0; i < 6; i++) send(29'h123, 0, 64'(i), 0, 0);
        chk("R9 no ovf at full", 64'(flags[2]), 0);
        send(29'h123, 0, 64'h99, 1, 0);
        chk("R9 ovf set", 64'(flags[2]), 1);
        chk("R10 handoff pulse", 64'(frm_to_mbx), 1);
        chk("R9 head unchanged", rd_data, 0);
        @(negedge clk);
        chk("R10 pulse one cycle", 64'(frm_to_mbx), 0);
        send(29'h123, 0, 64'h98, 0, 0);
        chk("R10 no handoff without mailbox", 64'(frm_to_mbx), 0);
        clr(3'b001);
        send(29'h123, 0, 64'h77, 0, 0);
        drain(n, l);
        chk("R9 accepted after pop count", 64'(n), 6);
        chk("R9 accepted after pop last", l, 64'h77);
        clr(3'b110);
        chk("R9 ovf cleared", 64'(flags[2]), 0);
    endtask

    task automatic t_swap_full;
        int n; logic [63:0] l;
        for (int i = 0; i < 6; i++) send(29'h123, 0, 64'(10 + i), 0, 0);
        send(29'h123, 0, 64'h20, 1, 1);
        chk("R11 no ovf on swap", 64'(flags[2]), 0);
        chk("R11 no handoff on swap", 64'(frm_to_mbx), 0);
        chk("R11 head advanced", rd_data, 11);
        drain(n, l);
        chk("R11 count kept", 64'(n), 6);
        chk("R11 new frame last", l, 64'h20);
        clr(3'b110);
    endtask

    task automatic t_irq;
        int n; logic [63:0] l;
        @(negedge clk); imask_we = 1; imask_wdata = 3'b001;
        @(negedge clk); imask_we = 0;
        chk("R12 no irq when empty", 64'(irq), 0);
        send(29'h123, 0, 64'h5, 0, 0);
        chk("R12 irq on avail", 64'(irq), 1);
        @(negedge clk); imask_we = 1; imask_wdata = 3'b100;
        @(negedge clk); imask_we = 0;
        chk("R12 masked off", 64'(irq), 0);
        drain(n, l);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        wr_flt(0, 32'(29'h123) << 1);
        wr_flt(1, 32'(29'h120) << 1);
        wr_flt(2, 32'h8000_0000 | (32'(29'h1ABCDE5) << 1));
        for (int i = 3; i < 8; i++) wr_flt(i, 32'h8000_0000 | 32'(i << 4));
        t_std_match();
        t_mask_priority();
        t_order();
        t_warn();
        t_overflow();
        t_swap_full();
        t_irq();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule